// File: doc/BRIEF.md
# Extended Superframe T1 Transmit Framer

This block builds the serial 1.544 Mb/s line stream in the 24-frame extended superframe layout, one line bit per clock. Each frame is one framing bit followed by the channel octets, most significant bit first. The framing bit is shared three ways:

- the odd frames carry a 4 kb/s data-link bit, pulled from a valid/ready input;
- frames 2, 6, 10, 14, 18 and 22 carry the six CRC-6 check bits;
- frames 4, 8, 12, 16, 20 and 24 carry the framing pattern.

Bit 8 of every channel is replaced by a signaling bit in frames 6, 12, 18 and 24.

Both data inputs follow valid/ready rules, but the line never stalls. The block raises `ch_ready` for exactly one cycle, on the first bit of each channel slot, and takes the octet and its signaling nibble on that edge. It raises `dl_ready` for one cycle on each data-link slot. If the matching valid is low at that moment, the slot is filled with ones. A source therefore applies back-pressure only by holding valid low, and the cost is an idle slot. The `tx_fsync` and `tx_sfsync` strobes line up with `tx_data` on the framing bit of each frame and of frame 1.

Top module: `esf_tx_framer`

## Requirements
- R1: A superframe is 24 frames of 1+8·NUM_CH bits, 4632 bits with the default 24 channels. `tx_fsync` is high for exactly the framing bit of every frame. `tx_sfsync` is high only on the framing bit of frame 1.
- R2: The framing bits of frames 4, 8, 12, 16, 20 and 24 carry 0, 0, 1, 0, 1, 1 in that order.
- R3: The framing bits of frames 2, 6, 10, 14, 18 and 22 carry check bits CB1..CB6 in that order, with CB1 the remainder MSB and CB6 its LSB.
- R4: The check bits are the remainder of the superframe's bits, MSB first and multiplied by x^6, divided by x^6+x+1 from a zero preset. Every framing bit counts as 1 and all other bits count as sent. The result goes out in the following superframe, and the first superframe after reset sends six zeros.
- R5: `dl_ready` is high only on the framing bit of odd frames. The line carries `dl_bit` when `dl_valid` is high and 1 otherwise. At any other time `dl_valid`/`dl_bit` have no effect.
- R6: `ch_ready` is high only on the first bit of each channel slot. The accepted `ch_octet` goes out MSB first over 8 bits, and 8'hFF is sent when `ch_valid` is low at acceptance. Inputs at any other time have no effect.
- R7: In frames 6, 12, 18 and 24, bit 8 of each channel carries `ch_sig[3]`, `ch_sig[2]`, `ch_sig[1]` and `ch_sig[0]` respectively (letters A, B, C, D), taken from the nibble accepted with that channel's octet. The nibble is 4'hF on underflow.
- R8: While `rst_n` is low, `tx_data`, `tx_fsync` and `tx_sfsync` are 0. The first bit after reset is the framing bit of frame 1, so `dl_ready` is high and `ch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid | input | 1 | Channel octet offered |
| ch_ready | output | 1 | Channel octet taken this edge |
| ch_octet | input | 8 | Channel octet, bit 7 sent first |
| ch_sig | input | 4 | Signaling nibble {A,B,C,D} for the channel |
| dl_valid | input | 1 | Data-link bit offered |
| dl_ready | output | 1 | Data-link bit taken this edge |
| dl_bit | input | 1 | Data-link bit |
| tx_data | output | 1 | Serial line bit |
| tx_fsync | output | 1 | High on each framing bit |
| tx_sfsync | output | 1 | High on the framing bit of frame 1 |

## Verification
A wrong position count shows at the ports within one frame. The ready strobes move off their slots, and the framing pattern and the strobes land on the wrong bits. A fault in the CRC register, or in its forced-one input, stays hidden for one superframe and then shows as wrong check bits in the next superframe's frames 2 to 22. The bench therefore runs four full superframes with underflow on both inputs, so it can compare every line bit against a division it performs itself.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int SF_FRAMES = 24;
  localparam int OCT_W     = 8;
  localparam int SIG_W     = 4;
  localparam int FRM_W     = $clog2(SF_FRAMES);
  localparam int CRC_W     = 6;
  localparam logic [CRC_W-1:0] CRC_POLY_LO = 6'b000011; // x^6 + x + 1

  // framing pattern bit for pattern slot k (frames 4,8,..,24)
  function automatic logic fas_bit(input logic [2:0] k);
    case (k)
      3'd2, 3'd4, 3'd5: fas_bit = 1'b1;
      default:          fas_bit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/esf_seq.sv
module esf_seq
  import esf_pkg::*;
#(
  parameter int NUM_CH = 24,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [FRM_W-1:0] frame_idx,
  output logic             fbit,
  output logic [CW-1:0]    chan_idx,
  output logic [2:0]       bit_idx,
  output logic             sf_end
);
  localparam logic [CW-1:0]    LAST_CH = CW'(NUM_CH - 1);
  localparam logic [FRM_W-1:0] LAST_FR = FRM_W'(SF_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_idx <= '0;
      fbit      <= 1'b1;
      chan_idx  <= '0;
      bit_idx   <= '0;
    end else if (fbit) begin
      fbit     <= 1'b0;
      chan_idx <= '0;
      bit_idx  <= '0;
    end else if (bit_idx == 3'd7) begin
      bit_idx <= '0;
      if (chan_idx == LAST_CH) begin
        chan_idx  <= '0;
        fbit      <= 1'b1;
        frame_idx <= (frame_idx == LAST_FR) ? '0 : frame_idx + 1'b1;
      end else begin
        chan_idx <= chan_idx + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assign sf_end = !fbit && (bit_idx == 3'd7) && (chan_idx == LAST_CH) &&
                  (frame_idx == LAST_FR);
endmodule

// File: rtl/esf_crc6.sv
module esf_crc6
  import esf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             block_end,
  output logic [CRC_W-1:0] rem_next
);
  logic [CRC_W-1:0] crc_q;

  assign rem_next = {crc_q[CRC_W-2:0], 1'b0} ^
                    ({CRC_W{bit_in ^ crc_q[CRC_W-1]}} & CRC_POLY_LO);

  always_ff @(posedge clk) begin
    if (!rst_n || block_end) crc_q <= '0;
    else                     crc_q <= rem_next;
  end
endmodule

// File: rtl/esf_fsel.sv
module esf_fsel
  import esf_pkg::*;
(
  input  logic [FRM_W-1:0] frame_idx,
  input  logic [CRC_W-1:0] cb_hold,
  input  logic             dl_val,
  output logic             f_val
);
  logic [2:0] slot;
  assign slot = frame_idx[FRM_W-1:2];

  always_comb begin
    if (!frame_idx[0])           f_val = dl_val;              // odd frame number
    else if (frame_idx[1] == 1'b0) f_val = cb_hold[3'd5 - slot]; // frames 2,6,..,22
    else                         f_val = fas_bit(slot);       // frames 4,8,..,24
  end
endmodule

// File: rtl/esf_tx_framer.sv
module esf_tx_framer
  import esf_pkg::*;
#(
  parameter int NUM_CH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_valid,
  output logic             ch_ready,
  input  logic [OCT_W-1:0] ch_octet,
  input  logic [SIG_W-1:0] ch_sig,
  input  logic             dl_valid,
  output logic             dl_ready,
  input  logic             dl_bit,
  output logic             tx_data,
  output logic             tx_fsync,
  output logic             tx_sfsync
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [FRM_W-1:0] frame_idx;
  logic             fbit, sf_end;
  logic [CW-1:0]    chan_idx;
  logic [2:0]       bit_idx;

  esf_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx), .fbit(fbit),
    .chan_idx(chan_idx), .bit_idx(bit_idx), .sf_end(sf_end)
  );

  // channel capture
  logic [OCT_W-1:0] oct_q, cur_oct;
  logic [SIG_W-1:0] sig_q, cur_sig;

  assign ch_ready = !fbit && (bit_idx == 3'd0);
  assign dl_ready = fbit && !frame_idx[0];

  always_comb begin
    if (ch_ready) begin
      cur_oct = ch_valid ? ch_octet : '1;
      cur_sig = ch_valid ? ch_sig   : '1;
    end else begin
      cur_oct = oct_q;
      cur_sig = sig_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oct_q <= '1;
      sig_q <= '1;
    end else if (ch_ready) begin
      oct_q <= cur_oct;
      sig_q <= cur_sig;
    end
  end

  // robbed-bit signaling
  logic       sig_frame;
  logic [1:0] letter;
  always_comb begin
    sig_frame = 1'b1;
    case (frame_idx)
      FRM_W'(5):  letter = 2'd0;
      FRM_W'(11): letter = 2'd1;
      FRM_W'(17): letter = 2'd2;
      FRM_W'(23): letter = 2'd3;
      default: begin
        letter    = 2'd0;
        sig_frame = 1'b0;
      end
    endcase
  end

  logic payload_bit;
  assign payload_bit = (sig_frame && bit_idx == 3'd7) ? cur_sig[2'd3 - letter]
                                                      : cur_oct[3'd7 - bit_idx];

  // framing bit and CRC
  logic [CRC_W-1:0] cb_hold, rem_next;
  logic             f_val, dl_val, line_bit;

  assign dl_val = dl_valid ? dl_bit : 1'b1;

  esf_fsel u_fsel (
    .frame_idx(frame_idx), .cb_hold(cb_hold), .dl_val(dl_val), .f_val(f_val)
  );

  assign line_bit = fbit ? f_val : payload_bit;

  esf_crc6 u_crc (
    .clk(clk), .rst_n(rst_n), .bit_in(fbit | line_bit),
    .block_end(sf_end), .rem_next(rem_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cb_hold <= '0;
    else if (sf_end) cb_hold <= rem_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data   <= 1'b0;
      tx_fsync  <= 1'b0;
      tx_sfsync <= 1'b0;
    end else begin
      tx_data   <= line_bit;
      tx_fsync  <= fbit;
      tx_sfsync <= fbit && (frame_idx == '0);
    end
  end
endmodule

// File: rtl/esf_tx_framer_chk.sv
module esf_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic ch_valid,
  input logic ch_ready,
  input logic dl_valid,
  input logic dl_ready,
  input logic tx_data,
  input logic tx_fsync,
  input logic tx_sfsync
);
  // R1
  sf_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sfsync |-> tx_fsync);
  // R1
  fsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fsync |=> !tx_fsync);
  // R5
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dl_ready && ch_ready));
  // R5
  dl_on_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_ready |=> tx_fsync);
  // R5
  dl_idle_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_ready && !dl_valid) |=> tx_data);
  // R6
  ch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |=> !ch_ready);
  // R6
  ch_idle_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ready && !ch_valid) |=> (tx_data && !tx_fsync));
endmodule

bind esf_tx_framer esf_tx_framer_chk u_chk (.*);

// File: tb/sim_esf_tx_framer.sv
`timescale 1ns/1ps
module sim_esf_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_valid = 1'b0, dl_valid = 1'b0, dl_bit = 1'b0;
  logic [7:0] ch_octet = '0;
  logic [3:0] ch_sig = '0;
  logic ch_ready, dl_ready, tx_data, tx_fsync, tx_sfsync;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  esf_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_octet(ch_octet), .ch_sig(ch_sig), .dl_valid(dl_valid),
    .dl_ready(dl_ready), .dl_bit(dl_bit), .tx_data(tx_data),
    .tx_fsync(tx_fsync), .tx_sfsync(tx_sfsync)
  );

  task automatic check(input string req, input int pos, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", req, pos, got, exp);
    end
  endtask

  function automatic logic [5:0] div_step(input logic [5:0] r, input logic b);
    logic [6:0] t;
    t = {r, b};
    if (t[6]) t = t ^ 7'b1000011;
    return t[5:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] brem, prev_rem, tmp;
    logic [7:0] e_oct;
    logic [3:0] e_sig;
    logic e_bit;
    string tag;
    prev_rem = '0;
    brem = '0;
    e_oct = '1;
    e_sig = '1;
    ch_valid = 1'b1;
    ch_octet = 8'h5A;
    dl_valid = 1'b1;
    dl_bit = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R8 data", -1, tx_data, 1'b0);
    check("R8 fsync", -1, tx_fsync, 1'b0);
    check("R8 sfsync", -1, tx_sfsync, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R8 dl_ready", 0, dl_ready, 1'b1);
    check("R8 ch_ready", 0, ch_ready, 1'b0);
    for (int sf = 0; sf < 4; sf++) begin
      for (int p = 0; p < 4632; p++) begin
        int f, b, ch, bi;
        logic fb;
        f = p / 193;
        b = p % 193;
        fb = (b == 0);
        ch = fb ? 0 : (b - 1) / 8;
        bi = fb ? 0 : (b - 1) % 8;
        // junk on non-slot cycles
        ch_valid = 1'b1;
        ch_octet = 8'hA5 ^ 8'(p);
        ch_sig = 4'(p * 3);
        dl_valid = 1'b1;
        dl_bit = 1'b0;
        if (fb) begin
          if (f % 2 == 0) begin
            dl_valid = !(sf == 2 && (f % 4 == 2));
            dl_bit = 1'((f / 2 + sf) & 1);
            e_bit = dl_valid ? dl_bit : 1'b1;
            tag = "R5 dlink";
          end else if (f % 4 == 1) begin
            e_bit = prev_rem[5 - f / 4];
            tag = "R3 R4 check bit";
          end else begin
            e_bit = 1'((6'b110100 >> (f / 4)) & 1);
            tag = "R2 pattern";
          end
        end else begin
          if (bi == 0) begin
            ch_valid = !(sf == 1 && ((ch + f) % 7 == 0));
            ch_octet = 8'((sf * 37 + f * 11 + ch * 5 + 3) & 255);
            ch_sig = 4'((f + ch + sf) & 15);
            e_oct = ch_valid ? ch_octet : 8'hFF;
            e_sig = ch_valid ? ch_sig : 4'hF;
          end
          if (bi == 7 && (f % 6 == 5)) begin
            e_bit = e_sig[3 - f / 6];
            tag = "R7 signaling";
          end else begin
            e_bit = e_oct[7 - bi];
            tag = "R6 payload";
          end
        end
        #0.5;
        check("R5 dl_ready", p, dl_ready, fb && (f % 2 == 0));
        check("R6 ch_ready", p, ch_ready, !fb && bi == 0);
        @(posedge clk);
        #1;
        check(tag, p, tx_data, e_bit);
        check("R1 fsync", p, tx_fsync, fb);
        check("R1 sfsync", p, tx_sfsync, p == 0);
        brem = div_step(brem, fb ? 1'b1 : e_bit);
        if (p == 4631) begin
          tmp = brem;
          for (int z = 0; z < 6; z++) tmp = div_step(tmp, 1'b0);
          prev_rem = tmp;
          brem = '0;
        end
        @(negedge clk);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule